// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block decodes one 32-bit instruction word for a small load/store RISC core. The word can take one of three formats: register (three register fields plus a shift amount and a function code), immediate (two register fields and a 16-bit constant) and jump (a 26-bit constant). The decoder is purely combinational. Its outputs are the register indices, the shift amount, a 32-bit constant already extended the way the operation needs, the destination register index, an ALU operation code and a set of control strobes for the datapath.

The covered groups are:

- register-format ALU and shift operations;
- immediate ALU operations;
- word load and word store;
- the two equality branches;
- the four jump forms.

Any other opcode or function code raises an illegal flag and blocks every register and memory write. A write aimed at register 0 is also dropped, because that register always reads as zero.

Top module: `insn_decoder`

## Requirements
- R1: `rs_idx`, `rt_idx`, `rd_idx` and `shamt` always carry bits 25:21, 20:16, 15:11 and 10:6 of `insn`. The opcode is bits 31:26 and the function code is bits 5:0.
- R2: The destination index `dest_idx` is taken from the instruction's fields according to its format:
  - register-format instructions write to `rd`;
  - immediate ALU operations and the word load write to `rt`;
  - the jump-and-link opcode 0x03 writes to register 31.
- R3: The constant `imm_ext` is the sign-extended 16-bit field for these opcodes: 0x08 (add), 0x09 (add unsigned), 0x0A (set-less-than), 0x0B (set-less-than unsigned), 0x23 (load word), 0x2B (store word), 0x04 (branch-equal) and 0x05 (branch-not-equal).
- R4: For opcodes 0x0C (and), 0x0D (or) and 0x0E (xor), `imm_ext` is the 16-bit field zero-extended.
- R5: For opcode 0x0F (load upper), `imm_ext` holds the 16-bit field in bits 31:16 with bits 15:0 zero, and `alu_op` is 11 (pass operand B).
- R6: `alu_op` uses this encoding: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 nor, 6 signed less-than, 7 unsigned less-than, 8 shift left, 9 shift right logical, 10 shift right arithmetic, 11 pass B.
  - Register-format function codes map as follows: 0x20/0x21 to 0, 0x22/0x23 to 1, 0x24 to 2, 0x25 to 3, 0x26 to 4, 0x27 to 5, 0x2A to 6, 0x2B to 7, 0x00/0x04 to 8, 0x02/0x06 to 9, 0x03/0x07 to 10.
  - Immediate opcodes map 0x08/0x09 to 0, 0x0A to 6, 0x0B to 7, 0x0C to 2, 0x0D to 3 and 0x0E to 4.
  - Load, store, jumps and illegal words give 0; branches give 1.
- R7: `shift_by_reg` is 1 only for the variable shifts (opcode 0, function 0x04, 0x06 or 0x07), whose amount comes from the `rs` register. It is 0 for the fixed shifts 0x00, 0x02 and 0x03.
- R8: `b_from_imm` is 1 for the immediate ALU opcodes 0x08–0x0F, for load and for store. It is 0 for register-format instructions, branches and jumps.
- R9: Load word (0x23) raises `mem_read`. Store word (0x2B) raises `mem_write` with `reg_write` at 0. The two are never both 1.
- R10: Opcodes 0x04 and 0x05 raise `is_branch`. `branch_ne` is 1 only for 0x05. Neither writes a register.
- R11: Jump signals:
  - opcode 0x02 raises `is_jump`, and opcode 0x03 also raises `link`;
  - opcode 0 with function 0x08 raises `is_jump` and `jump_reg`;
  - function 0x09 raises `is_jump`, `jump_reg` and `link`, with destination `rd`;
  - for opcodes 0x02/0x03, `imm_ext` is the 26-bit field zero-extended.
- R12: An opcode outside the listed set, or a function code outside the listed set under opcode 0, sets `illegal`. `reg_write`, `mem_read` and `mem_write` are then 0.
- R13: `reg_write` is 0 whenever `dest_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |
| rd_idx | output | 5 | Register-format destination field |
| shamt | output | 5 | Fixed shift amount field |
| imm_ext | output | 32 | Extended constant |
| dest_idx | output | 5 | Selected destination register |
| alu_op | output | 4 | ALU operation code |
| b_from_imm | output | 1 | ALU operand B taken from the constant |
| shift_by_reg | output | 1 | Shift amount taken from the rs register |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read strobe |
| mem_write | output | 1 | Data memory write strobe |
| is_branch | output | 1 | Conditional branch |
| branch_ne | output | 1 | Branch on not-equal (else equal) |
| is_jump | output | 1 | Unconditional jump of any form |
| jump_reg | output | 1 | Jump target from a register |
| link | output | 1 | Return address is written |
| illegal | output | 1 | Unsupported instruction |

## Verification
Some behaviours are checked by the assertions on every evaluation:

- writes to register 0 are suppressed;
- an illegal word is quiet, with no register or memory write;
- the memory strobes are mutually exclusive and a store writes no register;
- the constant has the right shape per class: copied sign for sign-extending opcodes, zero upper half for logical ones, zero lower half for load-upper.

Other behaviours need the bench's reference model across directed and random words. These are the exact ALU code per operation, the choice between `rd`, `rt` and register 31, the split between fixed and variable shifts, and which function codes count as legal.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int LINK_IDX = 31
) (
  input  logic [31:0] insn,
  output logic [4:0]  rs_idx,
  output logic [4:0]  rt_idx,
  output logic [4:0]  rd_idx,
  output logic [4:0]  shamt,
  output logic [31:0] imm_ext,
  output logic [4:0]  dest_idx,
  output logic [3:0]  alu_op,
  output logic        b_from_imm,
  output logic        shift_by_reg,
  output logic        reg_write,
  output logic        mem_read,
  output logic        mem_write,
  output logic        is_branch,
  output logic        branch_ne,
  output logic        is_jump,
  output logic        jump_reg,
  output logic        link,
  output logic        illegal
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_XOR = 4'd4, OP_NOR = 4'd5, OP_SLT = 4'd6, OP_SLTU = 4'd7,
                         OP_SLL = 4'd8, OP_SRL = 4'd9, OP_SRA = 4'd10, OP_PASSB = 4'd11;

  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_UPPER, EXT_JUMP} ext_e;

  logic [5:0] opc, fn;
  logic       known, wr_want, rd_want, st_want;
  ext_e       ext;

  assign opc    = insn[31:26];
  assign fn     = insn[5:0];
  assign rs_idx = insn[25:21];
  assign rt_idx = insn[20:16];
  assign rd_idx = insn[15:11];
  assign shamt  = insn[10:6];

  always_comb begin
    known        = 1'b1;
    wr_want      = 1'b0;
    rd_want      = 1'b0;
    st_want      = 1'b0;
    ext          = EXT_SIGN;
    dest_idx     = insn[20:16];
    alu_op       = OP_ADD;
    b_from_imm   = 1'b0;
    shift_by_reg = 1'b0;
    is_branch    = 1'b0;
    branch_ne    = 1'b0;
    is_jump      = 1'b0;
    jump_reg     = 1'b0;
    link         = 1'b0;
    case (opc)
      6'h00: begin
        dest_idx = insn[15:11];
        wr_want  = 1'b1;
        case (fn)
          6'h00: alu_op = OP_SLL;
          6'h02: alu_op = OP_SRL;
          6'h03: alu_op = OP_SRA;
          6'h04: begin alu_op = OP_SLL; shift_by_reg = 1'b1; end
          6'h06: begin alu_op = OP_SRL; shift_by_reg = 1'b1; end
          6'h07: begin alu_op = OP_SRA; shift_by_reg = 1'b1; end
          6'h08: begin is_jump = 1'b1; jump_reg = 1'b1; wr_want = 1'b0; end
          6'h09: begin is_jump = 1'b1; jump_reg = 1'b1; link = 1'b1; end
          6'h20, 6'h21: alu_op = OP_ADD;
          6'h22, 6'h23: alu_op = OP_SUB;
          6'h24: alu_op = OP_AND;
          6'h25: alu_op = OP_OR;
          6'h26: alu_op = OP_XOR;
          6'h27: alu_op = OP_NOR;
          6'h2A: alu_op = OP_SLT;
          6'h2B: alu_op = OP_SLTU;
          default: begin known = 1'b0; alu_op = OP_ADD; end
        endcase
      end
      6'h02: begin is_jump = 1'b1; ext = EXT_JUMP; end
      6'h03: begin
        is_jump  = 1'b1;
        link     = 1'b1;
        ext      = EXT_JUMP;
        wr_want  = 1'b1;
        dest_idx = 5'(LINK_IDX);
      end
      6'h04: begin is_branch = 1'b1; alu_op = OP_SUB; end
      6'h05: begin is_branch = 1'b1; branch_ne = 1'b1; alu_op = OP_SUB; end
      6'h08, 6'h09: begin b_from_imm = 1'b1; wr_want = 1'b1; end
      6'h0A: begin b_from_imm = 1'b1; wr_want = 1'b1; alu_op = OP_SLT; end
      6'h0B: begin b_from_imm = 1'b1; wr_want = 1'b1; alu_op = OP_SLTU; end
      6'h0C: begin b_from_imm = 1'b1; wr_want = 1'b1; alu_op = OP_AND; ext = EXT_ZERO; end
      6'h0D: begin b_from_imm = 1'b1; wr_want = 1'b1; alu_op = OP_OR;  ext = EXT_ZERO; end
      6'h0E: begin b_from_imm = 1'b1; wr_want = 1'b1; alu_op = OP_XOR; ext = EXT_ZERO; end
      6'h0F: begin b_from_imm = 1'b1; wr_want = 1'b1; alu_op = OP_PASSB; ext = EXT_UPPER; end
      6'h23: begin b_from_imm = 1'b1; wr_want = 1'b1; rd_want = 1'b1; end
      6'h2B: begin b_from_imm = 1'b1; st_want = 1'b1; end
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    case (ext)
      EXT_ZERO:  imm_ext = {16'h0000, insn[15:0]};
      EXT_UPPER: imm_ext = {insn[15:0], 16'h0000};
      EXT_JUMP:  imm_ext = {6'b000000, insn[25:0]};
      default:   imm_ext = {{16{insn[15]}}, insn[15:0]};
    endcase
  end

  assign illegal   = ~known;
  assign reg_write = known & wr_want & (dest_idx != 5'd0);
  assign mem_read  = known & rd_want;
  assign mem_write = known & st_want;
endmodule

module insn_decoder_chk (
  input logic [31:0] insn,
  input logic [31:0] imm_ext,
  input logic [4:0]  dest_idx,
  input logic        reg_write,
  input logic        mem_read,
  input logic        mem_write,
  input logic        illegal
);
  logic [5:0] opc;
  logic       sx_op;
  assign opc   = insn[31:26];
  assign sx_op = (opc == 6'h08) || (opc == 6'h09) || (opc == 6'h0A) || (opc == 6'h0B) ||
                 (opc == 6'h23) || (opc == 6'h2B) || (opc == 6'h04) || (opc == 6'h05);

  always_comb begin
    p_no_write_zero_r13: assert (!reg_write || dest_idx != 5'd0)
      else $error("write to register 0");
    p_illegal_quiet_r12: assert (!illegal || (!reg_write && !mem_read && !mem_write))
      else $error("illegal word not quiet");
    p_mem_excl_r9: assert (!(mem_read && mem_write))
      else $error("both memory strobes");
    p_store_no_reg_r9: assert (!mem_write || !reg_write)
      else $error("store writes a register");
    p_lui_low_r5: assert (opc != 6'h0F || imm_ext[15:0] == 16'h0000)
      else $error("load-upper low half not zero");
    p_zext_r4: assert (!(opc == 6'h0C || opc == 6'h0D || opc == 6'h0E) || imm_ext[31:16] == 16'h0000)
      else $error("logical constant not zero-extended");
    p_sext_r3: assert (!sx_op || imm_ext[31:16] == {16{imm_ext[15]}})
      else $error("constant not sign-extended");
  end
endmodule

bind insn_decoder insn_decoder_chk u_chk (
  .insn(insn), .imm_ext(imm_ext), .dest_idx(dest_idx), .reg_write(reg_write),
  .mem_read(mem_read), .mem_write(mem_write), .illegal(illegal)
);

// File: tb/sim_insn_decoder.sv
module sim_insn_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] insn = 32'h0;
  logic [4:0]  rs_idx, rt_idx, rd_idx, shamt, dest_idx;
  logic [31:0] imm_ext;
  logic [3:0]  alu_op;
  logic b_from_imm, shift_by_reg, reg_write, mem_read, mem_write;
  logic is_branch, branch_ne, is_jump, jump_reg, link, illegal;

  insn_decoder u0 (
    .insn(insn), .rs_idx(rs_idx), .rt_idx(rt_idx), .rd_idx(rd_idx), .shamt(shamt),
    .imm_ext(imm_ext), .dest_idx(dest_idx), .alu_op(alu_op), .b_from_imm(b_from_imm),
    .shift_by_reg(shift_by_reg), .reg_write(reg_write), .mem_read(mem_read),
    .mem_write(mem_write), .is_branch(is_branch), .branch_ne(branch_ne), .is_jump(is_jump),
    .jump_reg(jump_reg), .link(link), .illegal(illegal)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, logic [31:0] w);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s insn=%08h actual=%0h expected=%0h", tag, w, act, exp);
    end
  endtask

  task automatic compare(logic [31:0] w);
    int op = int'(w[31:26]);
    int fc = int'(w[5:0]);
    int e_alu = 0, e_dst = int'(w[20:16]);
    bit ok = 1, want = 0, e_bimm = 0, e_sbr = 0, e_mr = 0, e_mw = 0;
    bit e_br = 0, e_bne = 0, e_j = 0, e_jr = 0, e_lk = 0;
    logic [31:0] e_imm = {{16{w[15]}}, w[15:0]};
    if (op == 0) begin
      e_dst = int'(w[15:11]);
      want = 1;
      if (fc == 'h20 || fc == 'h21) e_alu = 0;
      else if (fc == 'h22 || fc == 'h23) e_alu = 1;
      else if (fc >= 'h24 && fc <= 'h27) e_alu = fc - 'h24 + 2;
      else if (fc == 'h2A) e_alu = 6;
      else if (fc == 'h2B) e_alu = 7;
      else if (fc == 0 || fc == 2 || fc == 3) e_alu = (fc == 0) ? 8 : fc + 7;
      else if (fc == 4 || fc == 6 || fc == 7) begin e_alu = (fc == 4) ? 8 : fc + 3; e_sbr = 1; end
      else if (fc == 8) begin e_j = 1; e_jr = 1; want = 0; end
      else if (fc == 9) begin e_j = 1; e_jr = 1; e_lk = 1; end
      else ok = 0;
    end else if (op == 2 || op == 3) begin
      e_j = 1;
      e_imm = {6'b0, w[25:0]};
      if (op == 3) begin e_lk = 1; want = 1; e_dst = 31; end
    end else if (op == 4 || op == 5) begin
      e_br = 1; e_bne = (op == 5); e_alu = 1;
    end else if (op >= 8 && op <= 'h0F) begin
      e_bimm = 1; want = 1;
      case (op)
        'h0A: e_alu = 6;
        'h0B: e_alu = 7;
        'h0C: e_alu = 2;
        'h0D: e_alu = 3;
        'h0E: e_alu = 4;
        'h0F: e_alu = 11;
        default: e_alu = 0;
      endcase
      if (op >= 'h0C && op <= 'h0E) e_imm = {16'h0, w[15:0]};
      if (op == 'h0F) e_imm = {w[15:0], 16'h0};
    end else if (op == 'h23) begin
      e_bimm = 1; want = 1; e_mr = 1;
    end else if (op == 'h2B) begin
      e_bimm = 1; e_mw = 1;
    end else ok = 0;

    chk("R1 rs", 32'(rs_idx), 32'(w[25:21]), w);
    chk("R1 rt", 32'(rt_idx), 32'(w[20:16]), w);
    chk("R1 rd", 32'(rd_idx), 32'(w[15:11]), w);
    chk("R1 shamt", 32'(shamt), 32'(w[10:6]), w);
    chk("R2 dest", 32'(dest_idx), 32'(e_dst), w);
    chk("R3/R4/R5/R11 imm", imm_ext, e_imm, w);
    chk("R6 alu_op", 32'(alu_op), 32'(e_alu), w);
    chk("R7 shift_by_reg", 32'(shift_by_reg), 32'(e_sbr), w);
    chk("R8 b_from_imm", 32'(b_from_imm), 32'(e_bimm), w);
    chk("R9 mem_read", 32'(mem_read), 32'(e_mr & ok), w);
    chk("R9 mem_write", 32'(mem_write), 32'(e_mw & ok), w);
    chk("R10 branch", 32'({is_branch, branch_ne}), 32'({e_br, e_bne}), w);
    chk("R11 jump", 32'({is_jump, jump_reg, link}), 32'({e_j, e_jr, e_lk}), w);
    chk("R12 illegal", 32'(illegal), 32'(!ok), w);
    chk("R12/R13 reg_write", 32'(reg_write), 32'(want && ok && e_dst != 0), w);
  endtask

  logic [31:0] vq[$];

  initial begin
    int legal_ops[14] = '{0, 2, 3, 4, 5, 8, 9, 'hA, 'hB, 'hC, 'hD, 'hE, 'hF, 'h2B};
    int legal_fn[18]  = '{0, 2, 3, 4, 6, 7, 8, 9, 'h20, 'h21, 'h22, 'h23, 'h24, 'h25, 'h26, 'h27, 'h2A, 'h2B};
    vq.push_back(32'h016A4820);
    vq.push_back(32'h00021100);
    vq.push_back(32'h01021004);
    vq.push_back(32'h2169FFFD);
    vq.push_back(32'h3528FFFF);
    vq.push_back(32'h3C08AAAA);
    vq.push_back(32'h8C088000);
    vq.push_back(32'hAC087FFC);
    vq.push_back(32'h1109FFFF);
    vq.push_back(32'h15090004);
    vq.push_back(32'h0BFFFFFF);
    vq.push_back(32'h0C000010);
    vq.push_back(32'h01000008);
    vq.push_back(32'h0100F809);
    vq.push_back(32'h00000020);
    vq.push_back(32'h20000001);
    vq.push_back(32'h8C000000);
    vq.push_back(32'h0000003F);
    vq.push_back(32'hFC000000);
    vq.push_back(32'h7D2A0000);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      if (i % 3 == 0) r[31:26] = 6'(legal_ops[$urandom_range(13)]);
      else if (i % 3 == 1) begin r[31:26] = 6'h00; r[5:0] = 6'(legal_fn[$urandom_range(17)]); end
      vq.push_back(r);
    end
    vq.push_back(32'h8C000004);
    vq.push_back(32'h00000000);

    @(negedge clk);
    compare(insn);
    while (vq.size() > 0) begin
      @(posedge clk);
      insn <= vq.pop_front();
      @(negedge clk);
      compare(insn);
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule